// File: doc/BRIEF.md
# Fermat-Chain Inverter for GF(2^m)

This block finds the multiplicative inverse of one element of the binary extension field GF(2^m), held in polynomial basis, by raising it to the power 2^m − 2. It walks a fixed addition chain over exponents of the form 2^k − 1. The chain is derived from the binary expansion of m − 1. For the default m = 113 the chain visits k = 1, 2, 3, 6, 7, 14, 28, 56 and 112, and one more squaring then gives the inverse. Because the schedule never looks at the operand, every input takes the same number of cycles. That includes zero, which comes out as zero.

The controller accepts one operand at a time. A one-cycle `start` loads the operand. `busy` stays high while the chain runs, and a one-cycle `done` marks the cycle in which `result` holds the inverse. Each squaring is a single-cycle combinational square-and-reduce. All chain multiplications share one bit-serial multiplier, which scans the stored operand MSB first and takes m cycles per product. The reduction polynomial is a parameter, with x^113 + x^9 + 1 as the default.

Top module: `fermat_field_inverse`

## Requirements
- R1: For a nonzero operand, `result` multiplied by the operand, reduced modulo the parameter polynomial, equals 1. Bit i of a field word is the coefficient of x^i. The default polynomial is x^113 + x^9 + 1, given as the low-term word 0x201.
- R2: An all-zero operand yields an all-zero `result`.
- R3: `done` rises exactly N clock edges after the edge that samples `start`, for every operand. N = (m − 1) + m·q, where q is the number of multiplications in the chain. q counts the bits of m − 1 below its most significant one, plus the ones among those bits. N is 1016 for m = 113 and 39 for m = 8.
- R4: `done` is high for one cycle only. After it, `result` keeps its value until the next accepted `start`.
- R5: `busy` is high from the edge that samples `start` until the edge that raises `done`. In the `done` cycle `busy` is low.
- R6: A `start` pulse while `busy` is high is ignored. The running computation finishes on its original schedule, with the result for the original operand.
- R7: During and right after synchronous active-low reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request; the operand is sampled with it when idle |
| operand | input | M | Field element to invert |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle completion flag |
| result | output | M | Inverse of the last accepted operand |

## Verification
A small field, m = 8 with polynomial x^8 + x^4 + x^3 + x + 1, is swept over all 256 operands. The bench checks each product with the input against 1, and checks each latency against the formula. A wrong squaring reduction or a misplaced chain step would show up there as a non-unit product. The default 113-bit field is driven with zero, one, x, the all-ones word and random words. A design that special-cased zero, or that stopped the chain early, would show a different latency or a wrong product. A second `start` is also pulsed in mid-run. A design that re-latched the operand would return the inverse of the wrong word or finish late. A `done` held high or a `result` that drifts after completion is also reported.

// File: rtl/finv_pkg.sv
// Shared types for the Fermat-chain field inverter.
package finv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SQR  = 2'd1,
        ST_MUL  = 2'd2,
        ST_FIN  = 2'd3
    } finv_state_t;
endpackage

// File: rtl/gf_sqr_reduce.sv
// Combinational squaring in GF(2^M), polynomial basis.
// Assumes POLY holds the low terms of a reduction polynomial x^M + POLY,
// and that all of its terms lie below x^M.
module gf_sqr_reduce #(
    parameter int          M    = 113,
    parameter logic [M-1:0] POLY = M'('h201)
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    localparam int W = 2*M - 1;

    logic [W-1:0] t;

    // spread the bits to even positions, then fold the high terms down
    always_comb begin
        t = '0;
        for (int i = 0; i < M; i++) t[2*i] = a[i];
        for (int i = W-1; i >= M; i--) begin
            if (t[i]) begin
                t[i] = 1'b0;
                t[i-M +: M] = t[i-M +: M] ^ POLY;
            end
        end
        y = t[M-1:0];
    end
endmodule

// File: rtl/gf_mac_step.sv
// One step of an MSB-first bit-serial multiplier in GF(2^M):
// y = p*x mod P(x), plus addend when en is set.
module gf_mac_step #(
    parameter int          M    = 113,
    parameter logic [M-1:0] POLY = M'('h201)
) (
    input  logic [M-1:0] p,
    input  logic [M-1:0] addend,
    input  logic         en,
    output logic [M-1:0] y
);
    logic [M-1:0] shifted;

    // multiply by x with conditional reduction, then accumulate
    always_comb begin
        shifted = {p[M-2:0], 1'b0} ^ (p[M-1] ? POLY : '0);
        y       = shifted ^ (en ? addend : '0);
    end
endmodule

// File: rtl/fermat_field_inverse.sv
// Field inverter: result = operand^(2^M - 2) over GF(2^M), polynomial basis.
// Walks the exponent chain 2^k - 1 taken from the bits of M-1. Doubling
// steps square k times and multiply by the saved value. Increment steps
// square once and multiply by the operand. One final squaring follows.
// The schedule is data-independent. Assumes M >= 3 and an irreducible
// polynomial.
module fermat_field_inverse
    import finv_pkg::*;
#(
    parameter int          M    = 113,
    parameter logic [M-1:0] POLY = M'('h201)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] operand,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] result
);
    localparam int KW  = $clog2(M) + 1;
    localparam int BW  = $clog2(KW);
    localparam int CW  = $clog2(M);
    localparam int LVL = $clog2(M) - 1;
    localparam logic [KW-1:0] CHAIN = KW'(M - 1);

    finv_state_t   state;
    logic [M-1:0]  acc, opa, save, pacc;
    logic [KW-1:0] k, cnt;
    logic [BW-1:0] bidx;
    logic [CW-1:0] mcnt;
    logic          sel_inc;
    logic [M-1:0]  sq_out, mac_out;
    logic          mul_bit;

    gf_sqr_reduce #(.M(M), .POLY(POLY)) u_sqr (
        .a (acc),
        .y (sq_out)
    );

    // pick the scanned multiplier bit: operand on increment steps, saved value on doublings
    always_comb mul_bit = sel_inc ? opa[mcnt] : save[mcnt];

    gf_mac_step #(.M(M), .POLY(POLY)) u_mac (
        .p      (pacc),
        .addend (acc),
        .en     (mul_bit),
        .y      (mac_out)
    );

    // chain sequencer: loads the operand, runs square and multiply phases, flags completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            acc     <= '0;
            opa     <= '0;
            save    <= '0;
            pacc    <= '0;
            k       <= '0;
            cnt     <= '0;
            bidx    <= '0;
            mcnt    <= '0;
            sel_inc <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        acc     <= operand;
                        opa     <= operand;
                        save    <= operand;
                        k       <= KW'(2);
                        cnt     <= KW'(1);
                        bidx    <= BW'(LVL - 1);
                        sel_inc <= 1'b0;
                        state   <= ST_SQR;
                    end
                end
                ST_SQR: begin
                    acc <= sq_out;
                    cnt <= cnt - 1'b1;
                    if (cnt == KW'(1)) begin
                        mcnt  <= CW'(M - 1);
                        pacc  <= '0;
                        state <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    pacc <= mac_out;
                    mcnt <= mcnt - 1'b1;
                    if (mcnt == '0) begin
                        acc <= mac_out;
                        if (!sel_inc && CHAIN[bidx]) begin
                            sel_inc <= 1'b1;
                            cnt     <= KW'(1);
                            k       <= k + 1'b1;
                            state   <= ST_SQR;
                        end else if (bidx != '0) begin
                            bidx    <= bidx - 1'b1;
                            save    <= mac_out;
                            cnt     <= k;
                            k       <= k << 1;
                            sel_inc <= 1'b0;
                            state   <= ST_SQR;
                        end else begin
                            state <= ST_FIN;
                        end
                    end
                end
                ST_FIN: begin
                    acc   <= sq_out;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign result = acc;

    // R3
    chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIN) |-> (k == KW'(M - 1)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    // R5
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(opa));
endmodule

// File: tb/test_fermat_field_inverse.sv
`timescale 1ns/1ps
module test_fermat_field_inverse;
    localparam int MB = 113;
    localparam int MS = 8;
    localparam logic [127:0] PB = 128'h201;
    localparam logic [127:0] PS = 128'h1B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          b_start = 1'b0, s_start = 1'b0;
    logic [MB-1:0] b_op = '0;
    logic [MS-1:0] s_op = '0;
    logic          b_busy, b_done, s_busy, s_done;
    logic [MB-1:0] b_res;
    logic [MS-1:0] s_res;

    int tests = 0;
    int fails = 0;

    fermat_field_inverse i_fermat_field_inverse (
        .clk(clk), .rst_n(rst_n), .start(b_start), .operand(b_op),
        .busy(b_busy), .done(b_done), .result(b_res));

    fermat_field_inverse #(.M(MS), .POLY(8'h1B)) i_fermat_field_inverse_small (
        .clk(clk), .rst_n(rst_n), .start(s_start), .operand(s_op),
        .busy(s_busy), .done(s_done), .result(s_res));

    // reference product, LSB-first shift and add
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b,
                                             input int m, input logic [127:0] poly);
        logic [127:0] r = '0;
        for (int i = 0; i < m; i++) begin
            if (b[i]) r ^= a;
            a = a << 1;
            if (a[m]) begin
                a[m] = 1'b0;
                a ^= poly;
            end
        end
        return r;
    endfunction

    // latency formula of R3
    function automatic int exp_lat(input int m);
        int v = m - 1;
        int top = 0;
        int q = 0;
        for (int i = 0; i < 32; i++) if (v[i]) top = i;
        for (int i = 0; i < top; i++) q += 1 + (v[i] ? 1 : 0);
        return (m - 1) + m * q;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_big(input logic [MB-1:0] op, input bit poke, input logic [MB-1:0] op2,
                           output logic [MB-1:0] res, output int lat);
        @(negedge clk); b_op = op; b_start = 1'b1;
        @(negedge clk); b_start = 1'b0; lat = 0;
        while (!b_done && lat < 3000) begin
            if (poke && lat == 100) begin
                chk(b_busy == 1'b1, "R5 busy mid-run", 128'(b_busy), 128'd1);
                b_op = op2; b_start = 1'b1;
            end else b_start = 1'b0;
            @(negedge clk); lat++;
        end
        b_start = 1'b0;
        chk(b_busy == 1'b0, "R5 busy low with done", 128'(b_busy), 128'd0);
        res = b_res;
    endtask

    task automatic run_small(input logic [MS-1:0] op, output logic [MS-1:0] res, output int lat);
        @(negedge clk); s_op = op; s_start = 1'b1;
        @(negedge clk); s_start = 1'b0; lat = 0;
        while (!s_done && lat < 3000) begin
            @(negedge clk); lat++;
        end
        res = s_res;
    endtask

    initial begin
        #(150000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [MB-1:0] r, op;
        logic [MS-1:0] rs;
        int lat;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(b_busy == 0 && b_done == 0 && b_res == '0, "R7 reset", 128'(b_res), 128'd0);
        chk(s_busy == 0 && s_done == 0 && s_res == '0, "R7 reset small", 128'(s_res), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive small field: R1, R2, R3
        for (int v = 0; v < 256; v++) begin
            run_small(MS'(v), rs, lat);
            chk(lat == exp_lat(MS), "R3 small latency", 128'(lat), 128'(exp_lat(MS)));
            if (v == 0) chk(rs == '0, "R2 small zero", 128'(rs), 128'd0);
            else chk(ref_mul(128'(rs), 128'(v), MS, PS) == 128'd1, "R1 small product",
                     ref_mul(128'(rs), 128'(v), MS, PS), 128'd1);
        end

        // default field, fixed patterns and random words
        for (int n = 0; n < 36; n++) begin
            case (n)
                0: op = '0;
                1: op = MB'(1);
                2: op = MB'(2);
                3: op = '1;
                default: op = MB'({$urandom, $urandom, $urandom, $urandom});
            endcase
            run_big(op, 1'b0, '0, r, lat);
            chk(lat == exp_lat(MB), "R3 latency", 128'(lat), 128'(exp_lat(MB)));
            if (op == '0) chk(r == '0, "R2 zero", 128'(r), 128'd0);
            else chk(ref_mul(128'(r), 128'(op), MB, PB) == 128'd1, "R1 product",
                     ref_mul(128'(r), 128'(op), MB, PB), 128'd1);
            if (n == 1) chk(r == MB'(1), "R1 inverse of one", 128'(r), 128'd1);
            // R4 done pulse and held result
            @(negedge clk);
            chk(b_done == 1'b0, "R4 done one cycle", 128'(b_done), 128'd0);
            repeat (3) @(negedge clk);
            chk(b_res == r, "R4 result held", 128'(b_res), 128'(r));
        end

        // R6 start while busy is ignored
        op = MB'({$urandom, $urandom, $urandom, $urandom}) | MB'(1);
        run_big(op, 1'b1, MB'(7), r, lat);
        chk(lat == exp_lat(MB), "R6 latency unchanged", 128'(lat), 128'(exp_lat(MB)));
        chk(ref_mul(128'(r), 128'(op), MB, PB) == 128'd1, "R6 original operand",
            ref_mul(128'(r), 128'(op), MB, PB), 128'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule